// File: doc/BRIEF.md
# Packet Burst Framer

This block drives the transmit direction of a 16-bit packet link toward a multi-port link-layer device. A packet source presents words one at a time, with start, end, odd-length and valid strobes and a target port number. The framer wraps each burst of data words in control words and fills every gap with idle control words. A control flag beside the 16-bit bus tells control words from data words.

Each port earns burst credit, counted in 8-word blocks of 16 bytes, from a 2-bit FIFO status code. The codes arrive one port at a time in round-robin order and are marked by a tick strobe. A sync strobe marks the code that belongs to port 0. A burst starts only when its port holds credit. A burst ends at the end of its packet, or at a block boundary once the credit runs out. Two packet starts on the bus are kept at least `SOP_GAP` word cycles apart.

The framer also enforces frame length limits. Short packets are padded with zero words up to `MIN_WORDS`, or closed with an abort status when padding is disabled. Packets that reach `MAX_WORDS` are cut at that point and closed with an abort status, and the rest of the packet is discarded.

Top module: `burst_framer`

## Requirements
- R1: After reset, out_ctl is 1, out_word is 16'h0000 (an idle control word with no status), in_ready is 0 and err_cnt is 0.
- R2: Control words have this layout: bit 15 is 1 for a payload word and 0 for an idle word, bits 14:13 hold the end status, bit 12 is the start-of-packet flag and bits 11:4 hold the port number, zero-extended. Bits 3:0 are 0. Idle words always have bits 12:0 at 0. Each payload control word is followed by the data words of its burst, in source order and back to back.
- R3: Within one burst, data words leave without a gap. After a burst, the bus returns to control words only at a multiple of 8 data words in the burst or at the end of the packet. Once credit runs out mid-packet, the packet continues later in a new burst whose payload control word has bit 12 clear.
- R4: A status tick with sync high applies to port 0. Each later tick applies to the next port, wrapping after NPORTS-1. Status code 00 sets the port's credit to MAXB1 blocks. Code 01 sets it to MAXB2 blocks. Codes 10 and 11 leave the credit unchanged. A burst starts only when its port's credit is nonzero. Every full or partial block sent uses one credit.
- R5: The end status of a burst is sent in the next control word: 01 for a normal end on a full last word, 10 for a normal end whose last word holds one byte, 11 for an abort, and 00 when the packet continues. A control word that directly follows another control word carries status 00.
- R6: A control word with the start flag set never comes fewer than SOP_GAP (8) word cycles after the previous one. While the source waits for this gap, idle words fill the time.
- R7: With pad_en high, a packet that ends before MIN_WORDS words is extended with 16'h0000 data words in the same burst up to MIN_WORDS words, and then ends with status 01.
- R8: With pad_en low, a packet that ends before MIN_WORDS words ends with status 11, and err_cnt increases by exactly 1, saturating at its maximum. err_cnt changes in no other case.
- R9: When a packet reaches MAX_WORDS words without ending, the burst ends with status 11 after word MAX_WORDS. The remaining source words are accepted (in_ready high) and dropped while idle words go out, and the next packet is framed normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_en | input | 1 | Pad short packets instead of aborting them |
| stat_tick | input | 1 | One FIFO status code is present this cycle |
| stat_sync | input | 1 | The present code belongs to port 0 |
| stat_code | input | 2 | FIFO status code of the current round-robin port |
| in_valid | input | 1 | Source word valid |
| in_sop | input | 1 | Source word is the first of a packet |
| in_eop | input | 1 | Source word is the last of a packet |
| in_odd | input | 1 | Last word carries only one valid byte |
| in_port | input | PW | Target port of the packet |
| in_data | input | 16 | Source data word |
| in_ready | output | 1 | Source word is taken at this clock edge |
| out_ctl | output | 1 | 1 when out_word is a control word |
| out_word | output | 16 | Data or control word on the bus |
| err_cnt | output | ERR_W | Count of short packets aborted |

## Verification
The framer is driven with single-burst packets of even and odd length. These show whether the end status reflects the last word's byte count. A packet longer than its port's credit shows whether the burst breaks at a block boundary and resumes as a continuation. Ports given status codes 10 and 11 show that no credit appears without 00 or 01. Short packets, with padding on and off, show zero-fill versus abort. Two back-to-back one-word packets expose the start spacing rule. An oversize packet followed by a normal one shows that truncation discards the tail without corrupting the next frame.

// File: rtl/bf_pkg.sv
package bf_pkg;
    localparam int WORD_W    = 16;
    localparam int BLK_WORDS = 8;

    typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_PAD, ST_DROP} fsm_e;
    typedef enum logic [1:0] {
        EOP_NONE  = 2'b00,
        EOP_EVEN  = 2'b01,
        EOP_ODD   = 2'b10,
        EOP_ABORT = 2'b11
    } eop_e;

    function automatic logic [WORD_W-1:0] ctl_word(logic payload, eop_e st, logic sop, logic [7:0] port);
        return {payload, st, sop, port, 4'b0000};
    endfunction
endpackage

// File: rtl/bf_credit.sv
module bf_credit #(
    parameter int NPORTS = 4,
    parameter int MAXB1  = 4,
    parameter int MAXB2  = 2,
    localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int CW    = $clog2(MAXB1 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_tick,
    input  logic              stat_sync,
    input  logic [1:0]        stat_code,
    input  logic              use_en,
    input  logic [PW-1:0]     use_port,
    output logic [NPORTS-1:0] avail_o,
    output logic [NPORTS-1:0] last_o
);
    logic [PW-1:0] rr_q, rr_d, slot;

    always_comb begin
        slot = stat_sync ? '0 : rr_q;
        rr_d = rr_q;
        if (stat_tick) rr_d = (slot == PW'(NPORTS - 1)) ? '0 : slot + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rr_q <= '0;
        else        rr_q <= rr_d;
    end

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        logic [CW-1:0] cr_q, cr_d;

        always_comb begin
            cr_d = cr_q;
            if (use_en && use_port == PW'(g) && cr_q != '0) cr_d = cr_q - CW'(1);
            if (stat_tick && slot == PW'(g)) begin
                case (stat_code)
                    2'b00:   cr_d = CW'(MAXB1);
                    2'b01:   cr_d = CW'(MAXB2);
                    default: cr_d = cr_d;
                endcase
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cr_q <= '0;
            else        cr_q <= cr_d;
        end

        assign avail_o[g] = (cr_q != '0);
        assign last_o[g]  = (cr_q == CW'(1));
    end
endmodule

// File: rtl/bf_sop_gap.sv
module bf_sop_gap #(
    parameter int GAP = 8,
    localparam int GW = $clog2(GAP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sop_fire,
    output logic gap_ok
);
    logic [GW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (sop_fire)                cnt_d = GW'(1);
        else if (cnt_q != GW'(GAP))  cnt_d = cnt_q + GW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= GW'(GAP);
        else        cnt_q <= cnt_d;
    end

    assign gap_ok = (cnt_q == GW'(GAP));
endmodule

// File: rtl/burst_framer.sv
module burst_framer
    import bf_pkg::*;
#(
    parameter int NPORTS    = 4,
    parameter int MAXB1     = 4,
    parameter int MAXB2     = 2,
    parameter int MIN_WORDS = 32,
    parameter int MAX_WORDS = 761,
    parameter int SOP_GAP   = 8,
    parameter int ERR_W     = 8,
    localparam int PW       = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int LW       = $clog2(MAX_WORDS + 1),
    localparam int BW       = $clog2(BLK_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pad_en,
    input  logic              stat_tick,
    input  logic              stat_sync,
    input  logic [1:0]        stat_code,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_odd,
    input  logic [PW-1:0]     in_port,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_ctl,
    output logic [WORD_W-1:0] out_word,
    output logic [ERR_W-1:0]  err_cnt
);
    typedef struct packed {
        fsm_e              st;
        eop_e              pend;
        logic [PW-1:0]     port;
        logic [LW-1:0]     cnt;
        logic [BW-1:0]     wcnt;
        logic              octl;
        logic [WORD_W-1:0] oword;
        logic [ERR_W-1:0]  err;
    } regs_t;

    regs_t q, d;
    logic [NPORTS-1:0] avail, last;
    logic use_en, sop_fire, gap_ok, start, blk_end;
    logic [LW-1:0] cnt_inc;

    bf_credit #(.NPORTS(NPORTS), .MAXB1(MAXB1), .MAXB2(MAXB2)) u_credit (
        .clk(clk), .rst_n(rst_n), .stat_tick(stat_tick), .stat_sync(stat_sync),
        .stat_code(stat_code), .use_en(use_en), .use_port(q.port),
        .avail_o(avail), .last_o(last)
    );

    bf_sop_gap #(.GAP(SOP_GAP)) u_gap (
        .clk(clk), .rst_n(rst_n), .sop_fire(sop_fire), .gap_ok(gap_ok)
    );

    always_comb begin
        d        = q;
        use_en   = 1'b0;
        sop_fire = 1'b0;
        start    = 1'b0;
        d.octl   = 1'b1;
        d.oword  = ctl_word(1'b0, EOP_NONE, 1'b0, 8'h00);
        cnt_inc  = q.cnt + LW'(1);
        blk_end  = (q.wcnt == BW'(BLK_WORDS - 1));
        case (q.st)
            ST_IDLE: begin
                start   = in_valid && avail[in_port] && (!in_sop || gap_ok);
                d.oword = ctl_word(start, q.pend, start && in_sop, start ? 8'(in_port) : 8'h00);
                d.pend  = EOP_NONE;
                if (start) begin
                    d.st     = ST_DATA;
                    d.port   = in_port;
                    d.wcnt   = '0;
                    sop_fire = in_sop;
                    if (in_sop) d.cnt = '0;
                end
            end
            ST_DATA: begin
                if (in_valid) begin
                    d.octl  = 1'b0;
                    d.oword = in_data;
                    d.cnt   = cnt_inc;
                    d.wcnt  = q.wcnt + BW'(1);
                    use_en  = blk_end;
                    if (in_eop) begin
                        if (cnt_inc < LW'(MIN_WORDS)) begin
                            if (pad_en) begin
                                d.st = ST_PAD;
                            end else begin
                                d.st   = ST_IDLE;
                                d.pend = EOP_ABORT;
                                use_en = 1'b1;
                                if (q.err != {ERR_W{1'b1}}) d.err = q.err + ERR_W'(1);
                            end
                        end else begin
                            d.st   = ST_IDLE;
                            d.pend = in_odd ? EOP_ODD : EOP_EVEN;
                            use_en = 1'b1;
                        end
                    end else if (cnt_inc == LW'(MAX_WORDS)) begin
                        d.st   = ST_DROP;
                        d.pend = EOP_ABORT;
                        use_en = 1'b1;
                    end else if (blk_end && last[q.port]) begin
                        d.st   = ST_IDLE;
                        d.pend = EOP_NONE;
                    end
                end
            end
            ST_PAD: begin
                d.octl  = 1'b0;
                d.oword = '0;
                d.cnt   = cnt_inc;
                d.wcnt  = q.wcnt + BW'(1);
                use_en  = blk_end;
                if (cnt_inc == LW'(MIN_WORDS)) begin
                    d.st   = ST_IDLE;
                    d.pend = EOP_EVEN;
                    use_en = 1'b1;
                end
            end
            ST_DROP: begin
                d.oword = ctl_word(1'b0, q.pend, 1'b0, 8'h00);
                d.pend  = EOP_NONE;
                if (in_valid && in_eop) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, pend: EOP_NONE, port: '0, cnt: '0, wcnt: '0,
                   octl: 1'b1, oword: '0, err: '0};
        end else begin
            q <= d;
        end
    end

    assign in_ready = (q.st == ST_DATA) || (q.st == ST_DROP);
    assign out_ctl  = q.octl;
    assign out_word = q.oword;
    assign err_cnt  = q.err;
endmodule

// File: rtl/bf_checks.sv
module bf_checks #(
    parameter int ERR_W   = 8,
    parameter int SOP_GAP = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_ctl,
    input logic [15:0]      out_word,
    input logic [ERR_W-1:0] err_cnt
);
    logic [2:0]       run_q;
    logic             prev_ctl_q;
    logic [ERR_W-1:0] prev_err_q;
    logic [4:0]       gap_q;
    logic             sop_ctl;

    assign sop_ctl = out_ctl && out_word[15] && out_word[12];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= '0;
            prev_ctl_q <= 1'b1;
            prev_err_q <= '0;
            gap_q      <= 5'(SOP_GAP);
        end else begin
            run_q      <= out_ctl ? 3'd0 : run_q + 3'd1;
            prev_ctl_q <= out_ctl;
            prev_err_q <= err_cnt;
            if (sop_ctl)                     gap_q <= 5'd1;
            else if (gap_q != 5'(SOP_GAP))   gap_q <= gap_q + 5'd1;
        end
    end

    assert_idle_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ctl && !out_word[15]) |-> (out_word[12:0] == 13'd0));

    assert_burst_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ctl && !prev_ctl_q) |-> (run_q == 3'd0 || out_word[14:13] != 2'b00));

    assert_status_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ctl && prev_ctl_q) |-> (out_word[14:13] == 2'b00));

    assert_sop_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sop_ctl |-> (gap_q == 5'(SOP_GAP)));

    assert_err_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cnt != prev_err_q) |-> (err_cnt == prev_err_q + ERR_W'(1)));
endmodule

bind burst_framer bf_checks #(.ERR_W(ERR_W), .SOP_GAP(SOP_GAP)) u_checks (
    .clk(clk), .rst_n(rst_n), .out_ctl(out_ctl), .out_word(out_word), .err_cnt(err_cnt)
);

// File: tb/test_burst_framer.sv
`timescale 1ns/1ps
module test_burst_framer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pad_en = 1'b0, stat_tick = 1'b0, stat_sync = 1'b0;
    logic [1:0] stat_code = 2'b10;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_odd = 1'b0;
    logic [1:0] in_port = '0;
    logic [15:0] in_data = '0;
    logic in_ready, out_ctl;
    logic [15:0] out_word;
    logic [7:0] err_cnt;

    int nchk = 0, nfail = 0, cyc = 0, sop_cyc = -100, sop_gap = 0;
    bit done = 0;
    logic [17:0] exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    burst_framer #(.MIN_WORDS(12), .MAX_WORDS(24)) i_burst_framer (
        .clk(clk), .rst_n(rst_n), .pad_en(pad_en), .stat_tick(stat_tick),
        .stat_sync(stat_sync), .stat_code(stat_code), .in_valid(in_valid),
        .in_sop(in_sop), .in_eop(in_eop), .in_odd(in_odd), .in_port(in_port),
        .in_data(in_data), .in_ready(in_ready), .out_ctl(out_ctl),
        .out_word(out_word), .err_cnt(err_cnt)
    );

    function automatic logic [15:0] dw(int p, int i);
        return 16'hA000 | 16'(p << 8) | 16'(i);
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // kinds: 0 data, 1 payload control {sop, port}, 2 end status
    task automatic push(logic [1:0] k, logic [15:0] v, string tag);
        exp_q.push_back({k, v});
        tag_q.push_back(tag);
    endtask
    task automatic exp_ctl(bit sop, int p, string tag);
        push(2'd1, {7'd0, sop, 8'(p)}, tag);
    endtask
    task automatic exp_data(int p, int from, int to, string tag);
        for (int i = from; i < to; i++) push(2'd0, dw(p, i), tag);
    endtask
    task automatic exp_pad(int n, string tag);
        for (int i = 0; i < n; i++) push(2'd0, 16'h0000, tag);
    endtask
    task automatic exp_stat(logic [1:0] s, string tag);
        push(2'd2, {14'd0, s}, tag);
    endtask

    task automatic got(logic [1:0] k, logic [15:0] v);
        logic [17:0] e;
        string t;
        if (exp_q.size() == 0) begin
            check(1'b0, "R2 unexpected word", {k, v}, 0);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(e == {k, v}, t, {k, v}, e);
        end
    endtask

    // monitor: turns the bus into a stream of events
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!out_ctl) begin
                got(2'd0, out_word);
            end else begin
                if (out_word[14:13] != 2'b00) got(2'd2, {14'd0, out_word[14:13]});
                if (out_word[15]) begin
                    got(2'd1, {7'd0, out_word[12], out_word[11:4]});
                    if (out_word[12]) begin
                        sop_gap = cyc - sop_cyc;
                        sop_cyc = cyc;
                    end
                end
            end
        end
    end

    task automatic give(int p, logic [1:0] c);
        for (int k = 0; k <= p; k++) begin
            @(negedge clk);
            stat_tick = 1'b1;
            stat_sync = (k == 0);
            stat_code = (k == p) ? c : 2'b10;
            @(negedge clk);
            stat_tick = 1'b0;
            stat_sync = 1'b0;
            stat_code = 2'b10;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic send(int p, int n, bit odd);
        int i = 0;
        while (i < n) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_port  = 2'(p);
            in_sop   = (i == 0);
            in_eop   = (i == n - 1);
            in_odd   = odd && (i == n - 1);
            in_data  = dw(p, i);
            if (in_ready) i++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_eop   = 1'b0;
        in_sop   = 1'b0;
    endtask

    task automatic settle();
        repeat (16) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(out_ctl == 1'b1, "R1 out_ctl", out_ctl, 1);
        check(out_word == 16'h0000, "R1 out_word", out_word, 0);
        check(in_ready == 1'b0, "R1 in_ready", in_ready, 0);
        check(err_cnt == 8'd0, "R1 err_cnt", err_cnt, 0);

        // R2/R5: even-length packet in one burst
        give(0, 2'b00);
        exp_ctl(1, 0, "R2 payload control");
        exp_data(0, 0, 14, "R2 data order");
        exp_stat(2'b01, "R5 even end");
        send(0, 14, 0);
        settle();

        // R5: odd-length end
        give(2, 2'b00);
        exp_ctl(1, 2, "R2 port field");
        exp_data(2, 0, 13, "R2 data odd packet");
        exp_stat(2'b10, "R5 odd end");
        send(2, 13, 0'b1);
        settle();

        // R3/R4: credit of two blocks splits a 20-word packet
        give(1, 2'b01);
        exp_ctl(1, 1, "R4 start with credit");
        exp_data(1, 0, 16, "R3 first burst");
        exp_ctl(0, 1, "R3 continuation");
        exp_data(1, 16, 20, "R3 second burst");
        exp_stat(2'b01, "R5 end after split");
        fork
            send(1, 20, 0);
            begin
                repeat (30) @(negedge clk);
                check(in_ready == 1'b0 && out_ctl == 1'b1, "R4 stalled without credit", in_ready, 0);
                give(1, 2'b01);
            end
        join
        settle();

        // R4: codes 11 and 10 grant nothing
        give(3, 2'b11);
        give(3, 2'b10);
        exp_ctl(1, 3, "R4 start after grant");
        exp_data(3, 0, 12, "R4 data");
        exp_stat(2'b01, "R5 end");
        fork
            send(3, 12, 0);
            begin
                repeat (20) @(negedge clk);
                check(in_ready == 1'b0 && out_word == 16'h0000, "R4 no credit from 10/11", out_word, 0);
                give(3, 2'b00);
            end
        join
        settle();

        // R7: padding
        pad_en = 1'b1;
        give(0, 2'b00);
        exp_ctl(1, 0, "R7 start");
        exp_data(0, 0, 5, "R7 data");
        exp_pad(7, "R7 zero fill");
        exp_stat(2'b01, "R7 end after pad");
        send(0, 5, 1'b1);
        settle();

        // R8: short packet without padding
        pad_en = 1'b0;
        give(0, 2'b00);
        exp_ctl(1, 0, "R8 start");
        exp_data(0, 0, 5, "R8 data");
        exp_stat(2'b11, "R8 abort");
        send(0, 5, 0);
        settle();
        check(err_cnt == 8'd1, "R8 err_cnt", err_cnt, 1);

        // R6: back-to-back one-word packets
        give(0, 2'b00);
        exp_ctl(1, 0, "R6 first");
        exp_data(0, 0, 1, "R6 data");
        exp_stat(2'b11, "R8 abort");
        exp_ctl(1, 0, "R6 second");
        exp_data(0, 0, 1, "R6 data");
        exp_stat(2'b11, "R8 abort");
        send(0, 1, 0);
        send(0, 1, 0);
        settle();
        check(sop_gap == 8, "R6 start spacing", sop_gap, 8);
        check(err_cnt == 8'd3, "R8 err_cnt", err_cnt, 3);

        // R9: truncation, then a clean packet
        give(2, 2'b00);
        exp_ctl(1, 2, "R9 start");
        exp_data(2, 0, 24, "R9 data to limit");
        exp_stat(2'b11, "R9 abort at limit");
        send(2, 30, 0);
        settle();
        check(err_cnt == 8'd3, "R9 err_cnt untouched", err_cnt, 3);
        give(2, 2'b00);
        exp_ctl(1, 2, "R9 next packet");
        exp_data(2, 0, 12, "R9 next data");
        exp_stat(2'b01, "R9 next end");
        send(2, 12, 0);
        settle();

        check(exp_q.size() == 0, "R5 all expected events seen", exp_q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule